// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select waveform for an SPI master, together with one-cycle shift and sample strobes for a separate data shifter. A sequencer starts a transfer and marks where each packet ends and which packet is the last. Every interval of the waveform is a programmable count of core-clock cycles: the non-idle and idle halves of each serial clock period, the chip-select lead-in before the first clock edge, the chip-select tail after the last edge, and the gap with chip-select released between packets.

The clock idle level, the edge on which data is shifted, the chip-select active level, the edge on which incoming data is sampled, and a delay of zero to seven core clocks applied to the sample strobe are all configuration inputs. These inputs are expected to stay constant during a transfer. A count of zero always gives an interval of one core clock.

Top module: `spi_tgen`

## Requirements
- R1: During and after reset, with no transfer started, SCK sits at the level of `cpol_i`, CS is at its inactive level, and both strobes are low.
- R2: A `start_i` seen on a clock edge while idle makes CS active from the next cycle, and SCK stays at its idle level for `setup_len_i`+1 cycles before the first edge.
- R3: In every bit SCK is at its non-idle level for `act_len_i`+1 cycles; between bits of one packet it returns to the idle level for `rest_len_i`+1 cycles. A count of zero gives one cycle.
- R4: SCK idle level equals `cpol_i` (0 gives idle-low, 1 idle-high); whenever CS is inactive, SCK is at that level.
- R5: `pkt_last_i` is sampled in the final non-idle cycle of each bit; when it is 1, SCK returns to idle and CS stays active for `hold_len_i`+1 cycles.
- R6: `xfer_last_i` is sampled in the final cycle of the CS tail: 1 ends the transfer; 0 releases CS for `gap_len_i`+1 cycles and then begins a new packet with a fresh lead-in.
- R7: `cs_pol_i`=1 makes CS active-high; `cs_pol_i`=0 makes it active-low.
- R8: `shift_stb_o` is a one-cycle pulse in the first cycle after an SCK edge: the leading edge of a bit (idle to non-idle) when `cpha_i`=1, the trailing edge (non-idle to idle) when `cpha_i`=0; one pulse per bit.
- R9: The sample edge is the leading edge of each bit when `cpha_i` XOR `late_samp_i` is 0, else the trailing edge.
- R10: `sample_stb_o` follows the sample edge by `tick_dly_i` cycles (0 to 7); with 0 it is in the same cycle a shift strobe for that edge would be.
- R11: No strobe is issued while CS is inactive; a delayed sample strobe that would fall after CS is released is dropped.
- R12: `start_i` has no effect while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer when idle |
| pkt_last_i | input | 1 | Current bit is the last of its packet |
| xfer_last_i | input | 1 | Current packet is the last of the transfer |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Shift on leading (1) or trailing (0) edge |
| cs_pol_i | input | 1 | CS active level |
| late_samp_i | input | 1 | Move the sample edge to the other edge of the bit |
| tick_dly_i | input | 3 | Sample strobe delay in core clocks |
| act_len_i | input | 16 | Non-idle SCK half length minus one |
| rest_len_i | input | 16 | Idle SCK half length minus one |
| setup_len_i | input | 16 | CS lead-in length minus one |
| hold_len_i | input | 16 | CS tail length minus one |
| gap_len_i | input | 8 | CS release between packets minus one |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| shift_stb_o | output | 1 | Shift strobe to the shifter |
| sample_stb_o | output | 1 | Sample strobe to the shifter |

## Verification
The hardest case to reach is a delayed sample strobe running past the end of the chip-select tail, which needs a late sample edge on the final bit, the longest tick delay and a one-cycle tail all at once; the bench builds exactly that combination and expects the strobe to vanish. Multi-packet transfers with the packet and transfer boundary inputs driven from the bench's own bit and packet counters reach the gap interval, and a second start pulse dropped into the middle of a long transfer shows that a busy generator ignores it. A second run with every count at zero exercises the one-cycle interval case under inverted clock polarity.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LEAD  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_HOLD  = 3'd4,
        ST_GAP   = 3'd5
    } tg_state_e;

endpackage

// File: rtl/spi_tgen_seq.sv
module spi_tgen_seq
    import spi_tgen_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pkt_last_i,
    input  logic             xfer_last_i,
    input  logic [CNT_W-1:0] act_len_i,
    input  logic [CNT_W-1:0] rest_len_i,
    input  logic [CNT_W-1:0] setup_len_i,
    input  logic [CNT_W-1:0] hold_len_i,
    input  logic [GAP_W-1:0] gap_len_i,
    output logic             cs_act_o,
    output logic             sck_act_o,
    output logic             edge_lead_o,
    output logic             edge_trail_o
);

    typedef struct packed {
        tg_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             e_lead;
        logic             e_trail;
    } seq_t;

    seq_t r_d, r_q;
    logic             cnt_zero;
    logic [CNT_W-1:0] cnt_dec;

    always_comb begin
        r_d         = r_q;
        r_d.e_lead  = 1'b0;
        r_d.e_trail = 1'b0;
        cnt_zero    = (r_q.cnt == '0);
        cnt_dec     = r_q.cnt - 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_SETUP;
                    r_d.cnt = setup_len_i;
                end
            end
            ST_SETUP: begin
                if (!cnt_zero) begin
                    r_d.cnt = cnt_dec;
                end else begin
                    r_d.st     = ST_LEAD;
                    r_d.cnt    = act_len_i;
                    r_d.e_lead = 1'b1;
                end
            end
            ST_LEAD: begin
                if (!cnt_zero) begin
                    r_d.cnt = cnt_dec;
                end else begin
                    r_d.e_trail = 1'b1;
                    if (pkt_last_i) begin
                        r_d.st  = ST_HOLD;
                        r_d.cnt = hold_len_i;
                    end else begin
                        r_d.st  = ST_TRAIL;
                        r_d.cnt = rest_len_i;
                    end
                end
            end
            ST_TRAIL: begin
                if (!cnt_zero) begin
                    r_d.cnt = cnt_dec;
                end else begin
                    r_d.st     = ST_LEAD;
                    r_d.cnt    = act_len_i;
                    r_d.e_lead = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!cnt_zero) begin
                    r_d.cnt = cnt_dec;
                end else if (xfer_last_i) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.st  = ST_GAP;
                    r_d.cnt = CNT_W'(gap_len_i);
                end
            end
            ST_GAP: begin
                if (!cnt_zero) begin
                    r_d.cnt = cnt_dec;
                end else begin
                    r_d.st  = ST_SETUP;
                    r_d.cnt = setup_len_i;
                end
            end
            default: begin
                r_d = '{st: ST_IDLE, cnt: '0, e_lead: 1'b0, e_trail: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, e_lead: 1'b0, e_trail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_act_o     = (r_q.st == ST_SETUP) || (r_q.st == ST_LEAD) ||
                          (r_q.st == ST_TRAIL) || (r_q.st == ST_HOLD);
    assign sck_act_o    = (r_q.st == ST_LEAD);
    assign edge_lead_o  = r_q.e_lead;
    assign edge_trail_o = r_q.e_trail;

    // R2: the cycle before any leading edge already had CS active
    assert_setup_precedes_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_lead_o |-> $past(cs_act_o));

    // R5: CS is still active right after the trailing edge of a bit
    assert_cs_held_after_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_trail_o |-> cs_act_o);

endmodule

// File: rtl/spi_tgen_strobe.sv
module spi_tgen_strobe #(
    parameter int TICK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_lead_i,
    input  logic              edge_trail_i,
    input  logic              cs_act_i,
    input  logic              cpha_i,
    input  logic              late_samp_i,
    input  logic [TICK_W-1:0] tick_i,
    output logic              shift_o,
    output logic              sample_o
);

    localparam int DEPTH = (1 << TICK_W) - 1;

    logic base_samp;
    logic shift_raw;

    assign shift_raw = cpha_i ? edge_lead_i : edge_trail_i;
    assign base_samp = (cpha_i ^ late_samp_i) ? edge_trail_i : edge_lead_i;
    assign shift_o   = cs_act_i & shift_raw;

    generate
        if (TICK_W == 0) begin : g_no_delay
            assign sample_o = cs_act_i & base_samp;
        end else begin : g_delay
            typedef struct packed {
                logic [DEPTH:1] dly;
            } dl_t;

            dl_t             s_d, s_q;
            logic [DEPTH:0]  taps;

            always_comb begin
                s_d        = s_q;
                s_d.dly[1] = base_samp;
                for (int k = 2; k <= DEPTH; k++) begin
                    s_d.dly[k] = s_q.dly[k-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s_q <= '0;
                end else begin
                    s_q <= s_d;
                end
            end

            assign taps     = {s_q.dly, base_samp};
            assign sample_o = cs_act_i & taps[tick_i];
        end
    endgenerate

    // R11: strobes appear only inside an active CS frame
    assert_strobe_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o || sample_o) |-> cs_act_i);

    // R8: a shift strobe never lasts two cycles
    assert_shift_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> !shift_o);

endmodule

// File: rtl/spi_tgen.sv
module spi_tgen
    import spi_tgen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int TICK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pkt_last_i,
    input  logic              xfer_last_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              cs_pol_i,
    input  logic              late_samp_i,
    input  logic [TICK_W-1:0] tick_dly_i,
    input  logic [CNT_W-1:0]  act_len_i,
    input  logic [CNT_W-1:0]  rest_len_i,
    input  logic [CNT_W-1:0]  setup_len_i,
    input  logic [CNT_W-1:0]  hold_len_i,
    input  logic [GAP_W-1:0]  gap_len_i,
    output logic              sck_o,
    output logic              cs_o,
    output logic              shift_stb_o,
    output logic              sample_stb_o
);

    logic cs_act;
    logic sck_act;
    logic edge_lead;
    logic edge_trail;

    spi_tgen_seq #(
        .CNT_W (CNT_W),
        .GAP_W (GAP_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pkt_last_i   (pkt_last_i),
        .xfer_last_i  (xfer_last_i),
        .act_len_i    (act_len_i),
        .rest_len_i   (rest_len_i),
        .setup_len_i  (setup_len_i),
        .hold_len_i   (hold_len_i),
        .gap_len_i    (gap_len_i),
        .cs_act_o     (cs_act),
        .sck_act_o    (sck_act),
        .edge_lead_o  (edge_lead),
        .edge_trail_o (edge_trail)
    );

    spi_tgen_strobe #(
        .TICK_W (TICK_W)
    ) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_lead_i  (edge_lead),
        .edge_trail_i (edge_trail),
        .cs_act_i     (cs_act),
        .cpha_i       (cpha_i),
        .late_samp_i  (late_samp_i),
        .tick_i       (tick_dly_i),
        .shift_o      (shift_stb_o),
        .sample_o     (sample_stb_o)
    );

    assign sck_o = sck_act ^ cpol_i;
    assign cs_o  = ~(cs_act ^ cs_pol_i);

    // R4: with CS released the serial clock rests at its idle level
    assert_sck_rests_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o != cs_pol_i) |-> (sck_o == cpol_i));

endmodule

// File: tb/spi_tgen_test.sv
module spi_tgen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pkt_last = 1'b0;
    logic        xfer_last = 1'b0;
    logic        cpol = 1'b0, cpha = 1'b0, cs_pol = 1'b0, late = 1'b0;
    logic [2:0]  tick = 3'd0;
    logic [15:0] act_len = 16'd1, rest_len = 16'd2, setup_len = 16'd3, hold_len = 16'd2;
    logic [7:0]  gap_len = 8'd1;
    logic        sck, cs, shift_stb, sample_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    spi_tgen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pkt_last_i(pkt_last),
        .xfer_last_i(xfer_last), .cpol_i(cpol), .cpha_i(cpha), .cs_pol_i(cs_pol),
        .late_samp_i(late), .tick_dly_i(tick), .act_len_i(act_len),
        .rest_len_i(rest_len), .setup_len_i(setup_len), .hold_len_i(hold_len),
        .gap_len_i(gap_len), .sck_o(sck), .cs_o(cs), .shift_stb_o(shift_stb),
        .sample_stb_o(sample_stb)
    );

    // behavioural reference: phase 0 idle, 1 lead-in, 2 clock high-side,
    // 3 clock rest, 4 tail, 5 gap
    int       m_ph = 0;
    int       m_left = 0;
    int       m_bit = 0;
    int       m_pkt = 0;
    bit       m_e1 = 0, m_e2 = 0;
    bit [7:0] m_hist = 0;
    int       nbits = 1, npkts = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_e1 = 0; m_e2 = 0; m_hist = 0;
        end else begin
            m_e1 = 0; m_e2 = 0;
            case (m_ph)
                0: if (start) begin m_ph = 1; m_left = setup_len; m_pkt = 0; end
                1: if (m_left > 0) m_left--; else begin m_ph = 2; m_left = act_len; m_e1 = 1; m_bit = 0; end
                2: if (m_left > 0) m_left--;
                   else begin
                       m_e2 = 1;
                       if (pkt_last) begin m_ph = 4; m_left = hold_len; end
                       else begin m_ph = 3; m_left = rest_len; end
                   end
                3: if (m_left > 0) m_left--; else begin m_ph = 2; m_left = act_len; m_e1 = 1; m_bit++; end
                4: if (m_left > 0) m_left--;
                   else if (xfer_last) m_ph = 0;
                   else begin m_ph = 5; m_left = gap_len; end
                5: if (m_left > 0) m_left--; else begin m_ph = 1; m_left = setup_len; m_pkt++; end
                default: m_ph = 0;
            endcase
            m_hist = {m_hist[6:0], ((cpha ^ late) ? m_e2 : m_e1)};
        end
    end

    // sequencer stand-in: boundary flags from the bench's own counters
    always @(negedge clk) begin
        pkt_last  <= (m_bit == nbits - 1);
        xfer_last <= (m_pkt == npkts - 1);
    end

    task automatic chk(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: got %b expected %b", tag, cycles, got, exp);
        end
    endtask

    int  shifts = 0;
    int  cs_rises = 0;
    bit  prev_act = 0;
    bit  cmp_on = 0;

    always @(negedge clk) begin
        #1;
        cycles++;
        if (cmp_on && rst_n) begin
            bit act;
            act = (m_ph >= 1 && m_ph <= 4);
            chk(sck, (m_ph == 2) ^ cpol, "R3 R4 sck");
            chk(cs, cs_pol ? act : !act, "R2 R5 R6 R7 cs");
            chk(shift_stb, act && (cpha ? m_e1 : m_e2), "R8 shift");
            chk(sample_stb, act && m_hist[tick], "R9 R10 R11 sample");
            if (shift_stb) shifts++;
            if ((cs == cs_pol) && !prev_act) cs_rises++;
            prev_act = (cs == cs_pol);
        end
    end

    task automatic xfer(input int bits, input int pkts, input bit poke);
        nbits = bits; npkts = pkts; shifts = 0; cs_rises = 0;
        repeat (2) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (m_ph != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        checks++;
        if (shifts != bits * pkts) begin
            errors++;
            $display("FAIL R8 shift count: got %0d expected %0d", shifts, bits * pkts);
        end
        if (poke) begin
            checks++;
            if (cs_rises != pkts) begin
                errors++;
                $display("FAIL R12 frames after busy start: got %0d expected %0d", cs_rises, pkts);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: quiet outputs in reset
        chk(sck, 1'b0, "R1 sck");
        chk(cs, 1'b1, "R1 cs");
        chk(shift_stb, 1'b0, "R1 shift");
        chk(sample_stb, 1'b0, "R1 sample");
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(cs, 1'b1, "R1 cs after reset");

        xfer(4, 1, 0);
        xfer(3, 3, 0);
        cpol = 1; cpha = 1; act_len = 0; rest_len = 0; setup_len = 0; hold_len = 0; gap_len = 0;
        xfer(5, 2, 0);
        cs_pol = 1; late = 1; tick = 3'd7; cpha = 0; cpol = 0; act_len = 2; rest_len = 1;
        xfer(3, 2, 0);
        hold_len = 12; tick = 3'd5; cpha = 1;
        xfer(4, 2, 0);
        late = 0; tick = 3'd2; act_len = 3; rest_len = 3; setup_len = 4; gap_len = 6;
        xfer(6, 2, 1);

        cmp_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, all requirements unfinished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule